// File: doc/BRIEF.md
# 64-bit Compare-Match Timer

This block is a memory-mapped timer built around a free-running 64-bit up-counter. Software sees the counter as two 32-bit words that can be read at any time and written to set a starting value. A 64-bit compare value, also held as two words, raises a sticky event flag once the counter has reached or passed it. The flag drives a single interrupt line through an enable bit. It is cleared by writing a one to it.

In one-shot use, a match fires once and the comparator then stays quiet until software reloads a compare word or turns the comparator off and on again. In periodic use, every match adds a 32-bit step value to the compare register, so events repeat at a fixed spacing with no software action. Access uses a word-addressed 32-bit register bus with separate read and write strobes. Read data is registered and appears one cycle after the read strobe.

Top module: `cmp_timer64`

## Requirements
- R1: After reset, every register (counter, compare, step, control, status) reads zero and `irq` is low.
- R2: Word addresses are 0 counter low, 1 counter high, 2 control, 3 status, 4 compare low, 5 compare high, 6 step. Control keeps bits [3:0] and reads zero above them. Address 7 reads zero. `rd_data` is updated on the clock edge where `rd_en` is high and shows the state before that edge.
- R3: While control bit 0 is set, the counter advances by one each clock and carries from the low word into the high word. While bit 0 is clear, the counter holds.
- R4: A write to one counter word loads that word, leaves the other word unchanged, and suppresses counting in that cycle.
- R5: Each counter word reads the live counter value, so a carry into the high word is visible between two reads.
- R6: The status bit 0 flag is set on an edge where counting (bit 0) and the comparator (bit 1) are enabled and counter >= compare, including when the counter is already strictly greater.
- R7: While control bit 1 is clear, writing either compare word never sets the flag.
- R8: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it set. The flag otherwise stays set.
- R9: `irq` is high exactly while the flag is set and control bit 2 is set.
- R10: With control bit 3 clear, a match fires once. After the flag is cleared it does not set again while the match condition persists, until a compare word is written or bit 1 is cleared.
- R11: With control bit 3 set, each match adds the step value to the compare register and sets the flag, so matches recur one step apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W (3) | Word address of the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W (32) | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W (32) | Registered read data |
| irq | output | 1 | Interrupt, flag AND interrupt enable |

## Verification
The compare is tried in three settings. A counter well above the compare value shows that greater-or-equal fires and not only equality. A counter above the compare while the comparator is disabled shows that compare writes stay silent. A periodic run with a step of ten shows that the compare advances once per match, and its final value is predicted from the stopped counter. The counter is preloaded just below a 32-bit boundary and read word by word while running, which separates live reads and carry from stale or split behaviour. Clearing the flag while the match still holds, then rewriting a compare word, distinguishes one-shot disarming from simple level sensing.

// File: rtl/ctmr_pkg.sv
// Shared types for the 64-bit compare-match timer.
// Assumes a word-addressed bus whose low three address bits pick a register.
package ctmr_pkg;

    // Register selector, taken from the low word-address bits.
    typedef enum logic [2:0] {
        SEL_CNT_LO = 3'd0,
        SEL_CNT_HI = 3'd1,
        SEL_CTRL   = 3'd2,
        SEL_STAT   = 3'd3,
        SEL_CMP_LO = 3'd4,
        SEL_CMP_HI = 3'd5,
        SEL_STEP   = 3'd6,
        SEL_NONE   = 3'd7
    } reg_sel_e;

    // Control fields; the packed order puts run in bit 0 and periodic in bit 3.
    typedef struct packed {
        logic periodic;
        logic irq_en;
        logic cmp_en;
        logic run;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/ctmr_regbus.sv
// Register decode, control and step storage, and registered read mux.
// Assumes address bits above bit 2 must be zero for a register to hit.
module ctmr_regbus
    import ctmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr_en,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  rd_en,
    input  logic [2*DATA_W-1:0]   cnt_i,
    input  logic [2*DATA_W-1:0]   cmp_i,
    input  logic                  flag_i,
    output ctrl_t                 ctrl_o,
    output logic [DATA_W-1:0]     step_o,
    output logic [DATA_W-1:0]     rd_data_o,
    output logic                  we_cnt_lo_o,
    output logic                  we_cnt_hi_o,
    output logic                  we_cmp_lo_o,
    output logic                  we_cmp_hi_o,
    output logic                  stat_clr_o
);

    localparam int unsigned CNT_W = 2 * DATA_W;

    logic       upper_zero;
    reg_sel_e   sel;
    logic       wr_hit;
    logic [DATA_W-1:0] rd_mux;
    ctrl_t      ctrl_q;
    logic [DATA_W-1:0] step_q;
    logic [DATA_W-1:0] rd_q;

    // Address bits above the selector must be zero; only present when ADDR_W > 3.
    if (ADDR_W > 3) begin : g_wide_addr
        assign upper_zero = (addr[ADDR_W-1:3] == '0);
    end else begin : g_narrow_addr
        assign upper_zero = 1'b1;
    end

    assign sel    = reg_sel_e'(addr[2:0]);
    assign wr_hit = wr_en && upper_zero;

    assign we_cnt_lo_o = wr_hit && (sel == SEL_CNT_LO);
    assign we_cnt_hi_o = wr_hit && (sel == SEL_CNT_HI);
    assign we_cmp_lo_o = wr_hit && (sel == SEL_CMP_LO);
    assign we_cmp_hi_o = wr_hit && (sel == SEL_CMP_HI);
    assign stat_clr_o  = wr_hit && (sel == SEL_STAT) && wr_data[0];

    // Control register: loads its low field bits on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_hit && (sel == SEL_CTRL)) begin
            ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    // Step register: the amount added to the compare value per periodic match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (wr_hit && (sel == SEL_STEP)) begin
            step_q <= wr_data;
        end
    end

    // Read mux: selects the addressed register, zero for unmapped addresses.
    always_comb begin
        rd_mux = '0;
        if (upper_zero) begin
            case (sel)
                SEL_CNT_LO: rd_mux = cnt_i[DATA_W-1:0];
                SEL_CNT_HI: rd_mux = cnt_i[CNT_W-1:DATA_W];
                SEL_CTRL:   rd_mux[CTRL_W-1:0] = ctrl_q;
                SEL_STAT:   rd_mux[0] = flag_i;
                SEL_CMP_LO: rd_mux = cmp_i[DATA_W-1:0];
                SEL_CMP_HI: rd_mux = cmp_i[CNT_W-1:DATA_W];
                SEL_STEP:   rd_mux = step_q;
                default:    rd_mux = '0;
            endcase
        end
    end

    // Read data register: captures the mux on a read strobe, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= rd_mux;
        end
    end

    assign ctrl_o    = ctrl_q;
    assign step_o    = step_q;
    assign rd_data_o = rd_q;

endmodule

// File: rtl/ctmr_counter.sv
// Free-running 2*DATA_W-bit up-counter with per-word load.
// Assumes a word load wins over counting in the same cycle.
module ctmr_counter #(
    parameter int unsigned DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_i,
    input  logic                  we_lo_i,
    input  logic                  we_hi_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [2*DATA_W-1:0]   cnt_o
);

    localparam int unsigned CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] cnt_q;

    // Counter: word loads take priority, else increment while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (we_lo_i || we_hi_i) begin
            if (we_lo_i) begin
                cnt_q[DATA_W-1:0] <= wdata_i;
            end
            if (we_hi_i) begin
                cnt_q[CNT_W-1:DATA_W] <= wdata_i;
            end
        end else if (run_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/ctmr_compare.sv
// Compare register, one-shot arming, periodic step and sticky event flag.
// Assumes counter and compare are both unsigned 2*DATA_W-bit values.
module ctmr_compare #(
    parameter int unsigned DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_i,
    input  logic                  cmp_en_i,
    input  logic                  periodic_i,
    input  logic [2*DATA_W-1:0]   cnt_i,
    input  logic [DATA_W-1:0]     step_i,
    input  logic                  we_lo_i,
    input  logic                  we_hi_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic                  stat_clr_i,
    output logic [2*DATA_W-1:0]   cmp_o,
    output logic                  flag_o
);

    localparam int unsigned CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] cmp_q;
    logic             armed_q;
    logic             flag_q;
    logic             reached;
    logic             fire;

    assign reached = (cnt_i >= cmp_q);
    assign fire    = run_i && cmp_en_i && reached && (periodic_i || armed_q);

    // Compare value: word loads, else advance by the step on a periodic match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (we_lo_i || we_hi_i) begin
            if (we_lo_i) begin
                cmp_q[DATA_W-1:0] <= wdata_i;
            end
            if (we_hi_i) begin
                cmp_q[CNT_W-1:DATA_W] <= wdata_i;
            end
        end else if (fire && periodic_i) begin
            cmp_q <= cmp_q + CNT_W'(step_i);
        end
    end

    // Arming: a one-shot match disarms, reload or comparator-off re-arms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
        end else if (!cmp_en_i || we_lo_i || we_hi_i) begin
            armed_q <= 1'b1;
        end else if (fire && !periodic_i) begin
            armed_q <= 1'b0;
        end
    end

    // Event flag: set by a match, cleared by write-one, set wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (fire) begin
            flag_q <= 1'b1;
        end else if (stat_clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign cmp_o  = cmp_q;
    assign flag_o = flag_q;

endmodule

// File: rtl/cmp_timer64.sv
// Top of the 64-bit compare-match timer: bus decode, counter, comparator.
// Assumes a single clock, synchronous active-low reset, divide-by-one counting.
module cmp_timer64
    import ctmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);

    localparam int unsigned CNT_W = 2 * DATA_W;

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] step_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cmp_q;
    logic              flag_q;
    logic              we_cnt_lo;
    logic              we_cnt_hi;
    logic              we_cmp_lo;
    logic              we_cmp_hi;
    logic              stat_clr;

    ctmr_regbus #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (addr),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_en       (rd_en),
        .cnt_i       (cnt_q),
        .cmp_i       (cmp_q),
        .flag_i      (flag_q),
        .ctrl_o      (ctrl_q),
        .step_o      (step_q),
        .rd_data_o   (rd_data),
        .we_cnt_lo_o (we_cnt_lo),
        .we_cnt_hi_o (we_cnt_hi),
        .we_cmp_lo_o (we_cmp_lo),
        .we_cmp_hi_o (we_cmp_hi),
        .stat_clr_o  (stat_clr)
    );

    ctmr_counter #(
        .DATA_W (DATA_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (ctrl_q.run),
        .we_lo_i (we_cnt_lo),
        .we_hi_i (we_cnt_hi),
        .wdata_i (wr_data),
        .cnt_o   (cnt_q)
    );

    ctmr_compare #(
        .DATA_W (DATA_W)
    ) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (ctrl_q.run),
        .cmp_en_i   (ctrl_q.cmp_en),
        .periodic_i (ctrl_q.periodic),
        .cnt_i      (cnt_q),
        .step_i     (step_q),
        .we_lo_i    (we_cmp_lo),
        .we_hi_i    (we_cmp_hi),
        .wdata_i    (wr_data),
        .stat_clr_i (stat_clr),
        .cmp_o      (cmp_q),
        .flag_o     (flag_q)
    );

    assign irq = flag_q && ctrl_q.irq_en;

endmodule

// File: rtl/ctmr_checker.sv
// Protocol checker for cmp_timer64, bound into the top.
// Assumes the top exposes ctrl_q, cnt_q, cmp_q, step_q and flag_q.
module ctmr_checker #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   addr,
    input logic                wr_en,
    input logic                run,
    input logic                cmp_en,
    input logic                periodic,
    input logic [2*DATA_W-1:0] cnt,
    input logic [2*DATA_W-1:0] cmp,
    input logic [DATA_W-1:0]   step,
    input logic                flag
);

    localparam int unsigned CNT_W = 2 * DATA_W;

    logic cnt_wr;
    logic cmp_wr;
    logic stat_wr;

    assign cnt_wr  = wr_en && ((addr == ADDR_W'(0)) || (addr == ADDR_W'(1)));
    assign cmp_wr  = wr_en && ((addr == ADDR_W'(4)) || (addr == ADDR_W'(5)));
    assign stat_wr = wr_en && (addr == ADDR_W'(3));

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cnt));                              // R3
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_wr) |=> (cnt == $past(cnt) + CNT_W'(1)));           // R3
    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(run && cmp_en && (cnt >= cmp)));            // R6
    AST_NO_EVT_CMP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> !$rose(flag));                                        // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !stat_wr) |=> flag);                                     // R8
    AST_PERIODIC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cmp_en && periodic && (cnt >= cmp) && !cmp_wr)
        |=> (cmp == $past(cmp) + CNT_W'($past(step))));                  // R11

endmodule

bind cmp_timer64 ctmr_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .run      (ctrl_q.run),
    .cmp_en   (ctrl_q.cmp_en),
    .periodic (ctrl_q.periodic),
    .cnt      (cnt_q),
    .cmp      (cmp_q),
    .step     (step_q),
    .flag     (flag_q)
);

// File: tb/tb_cmp_timer64.sv
`timescale 1ns/100ps
module tb_cmp_timer64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    cmp_timer64 dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .irq     (irq)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 50000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // R1: every register reads zero after reset and irq is low.
    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 7; a++) begin
            bus_read(3'(a), v);
            check("R1", $sformatf("reg %0d after reset", a), 64'(v), 64'h0);
        end
        check("R1", "irq after reset", 64'(irq), 64'h0);
    endtask

    // R2: control width, step readback, unmapped read.
    task automatic t_regmap();
        logic [31:0] v;
        bus_write(3'd2, 32'hFFFF_FFF0);
        bus_read(3'd2, v);
        check("R2", "control upper bits read zero", 64'(v), 64'h0);
        bus_write(3'd6, 32'hA5A5_0123);
        bus_read(3'd6, v);
        check("R2", "step readback", 64'(v), 64'hA5A5_0123);
        bus_read(3'd7, v);
        check("R2", "unmapped address", 64'(v), 64'h0);
        bus_write(3'd2, 32'h9);
        bus_read(3'd2, v);
        check("R2", "control readback", 64'(v), 64'h9);
        bus_write(3'd2, 32'h0);
    endtask

    // R3 R4 R5: word loads, hold, counting with carry, load priority.
    task automatic t_counter();
        logic [31:0] v;
        bus_write(3'd0, 32'hFFFF_FFFE);
        bus_write(3'd1, 32'h0000_0001);
        idle(3);
        bus_read(3'd0, v);
        check("R3", "low held while stopped", 64'(v), 64'hFFFF_FFFE);
        bus_read(3'd1, v);
        check("R4", "high word loaded", 64'(v), 64'h1);
        bus_write(3'd2, 32'h1);
        bus_read(3'd0, v);
        check("R3", "low at first running edge", 64'(v), 64'hFFFF_FFFE);
        bus_read(3'd1, v);
        check("R5", "high before carry", 64'(v), 64'h1);
        bus_read(3'd0, v);
        check("R5", "low after wrap", 64'(v), 64'h0);
        bus_read(3'd1, v);
        check("R5", "high after carry", 64'(v), 64'h2);
        bus_write(3'd0, 32'h5);
        bus_read(3'd0, v);
        check("R4", "load wins over count", 64'(v), 64'h5);
        bus_read(3'd1, v);
        check("R4", "high unchanged by low load", 64'(v), 64'h2);
        bus_write(3'd2, 32'h0);
    endtask

    // R6 R7 R8 R9 R10: greater-or-equal one-shot behaviour.
    task automatic t_oneshot();
        logic [31:0] v;
        bus_write(3'd3, 32'h1);
        bus_write(3'd0, 32'd1000);
        bus_write(3'd1, 32'd0);
        bus_write(3'd2, 32'h1);
        bus_write(3'd4, 32'd5);
        bus_write(3'd5, 32'd0);
        idle(3);
        bus_read(3'd3, v);
        check("R7", "no event while comparator off", 64'(v), 64'h0);
        bus_write(3'd2, 32'h7);
        idle(2);
        bus_read(3'd3, v);
        check("R6", "flag on counter above compare", 64'(v), 64'h1);
        check("R9", "irq with enable", 64'(irq), 64'h1);
        bus_write(3'd2, 32'h3);
        check("R9", "irq masked", 64'(irq), 64'h0);
        bus_write(3'd3, 32'h0);
        bus_read(3'd3, v);
        check("R8", "write zero keeps flag", 64'(v), 64'h1);
        bus_write(3'd3, 32'h1);
        idle(5);
        bus_read(3'd3, v);
        check("R10", "no re-fire after clear", 64'(v), 64'h0);
        bus_write(3'd4, 32'd5);
        idle(2);
        bus_read(3'd3, v);
        check("R10", "re-armed by compare write", 64'(v), 64'h1);
        bus_write(3'd2, 32'h0);
        bus_write(3'd3, 32'h1);
        bus_read(3'd3, v);
        check("R8", "write one clears", 64'(v), 64'h0);
    endtask

    // R11: periodic stepping of the compare value.
    task automatic t_periodic();
        logic [31:0] v;
        logic [31:0] c;
        int n;
        bus_write(3'd0, 32'd0);
        bus_write(3'd1, 32'd0);
        bus_write(3'd4, 32'd20);
        bus_write(3'd5, 32'd0);
        bus_write(3'd6, 32'd10);
        bus_write(3'd3, 32'h1);
        bus_write(3'd2, 32'hB);
        idle(60);
        bus_write(3'd2, 32'h0);
        bus_read(3'd0, c);
        n = (c >= 21) ? (int'(c) - 21) / 10 + 1 : 0;
        bus_read(3'd4, v);
        check("R11", "compare advanced per match", 64'(v), 64'(20 + 10 * n));
        bus_read(3'd5, v);
        check("R11", "compare high word", 64'(v), 64'h0);
        bus_read(3'd3, v);
        check("R11", "flag set by periodic match", 64'(v), 64'h1);
        check("R9", "irq low with enable clear", 64'(irq), 64'h0);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_counter();
        t_oneshot();
        t_periodic();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule